// File: doc/BRIEF.md
# Parallel Classifier Core Dispatch Controller

This controller takes single register transfers from a command sequencer and delivers each one to one of several pattern-classifier cores wired in parallel. The cores run on a clock four times slower than the controller, so every access is stretched into a window of four controller clocks. During that window the register address, the data word and either a write strobe or a read strobe reach the chosen core. A write carries training data into the core. A read drives the test data with the read strobe, then latches the distance and category that the core reports and returns them to the sequencer with a one-cycle valid pulse.

The core index is a binary number. An index that names no core is dropped and the controller stays idle. A busy output covers the whole access window, and a request that arrives while busy is ignored. The sequencer must wait for busy to fall before it issues the next transfer. The controller does not pick a winner among the results from different cores.

Top module: `multicore_dispatch`

## Requirements
- R1: During and just after reset, busy, rsp_valid, core_wr, core_rd and every bit of core_sel are 0.
- R2: When idle, a write request (req_wr=1, req_rd=0) with an index below N_CORES starts a window of exactly CLK_RATIO (4) clocks. In that window busy=1, core_sel has only bit req_sel set, core_wr=1, core_rd=0, and core_addr/core_wdata equal the request's address and data, all held steady.
- R3: A read request (req_rd=1) with a valid index starts a window of the same length and selection, with core_rd=1 and core_wr=0.
- R4: The result of a read is the distance field (bits i*DIST_W upward of core_dist_bus) and category field (bits i*CAT_W upward of core_cat_bus) of the selected core i. The values are the ones present on the third clock of the window (phase index SAMPLE_PHASE=2). Values that change after that clock are not seen.
- R5: rsp_valid is a pulse of one clock, in the clock right after a read window ends. A write window never raises it.
- R6: A request that arrives while busy=1 is ignored. The ongoing window keeps its address, data, select and length, and no second window follows.
- R7: A request whose index is N_CORES or higher is ignored. busy and every strobe stay 0.
- R8: If req_wr and req_rd are both 1, the transfer is a read.
- R9: rsp_dist and rsp_cat keep the last read result until the next read captures new values. Write windows leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (four times the core clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr | input | 1 | Write (learning) request |
| req_rd | input | 1 | Read (recognition) request |
| req_sel | input | SEL_W | Binary index of the target core |
| req_addr | input | ADDR_W | Core register address |
| req_data | input | DATA_W | Data word for the core |
| busy | output | 1 | Access window in progress |
| rsp_valid | output | 1 | One-cycle pulse: result available |
| rsp_dist | output | DIST_W | Captured distance |
| rsp_cat | output | CAT_W | Captured category |
| core_sel | output | N_CORES | One-hot core select |
| core_wr | output | 1 | Write strobe to the selected core |
| core_rd | output | 1 | Read strobe to the selected core |
| core_addr | output | ADDR_W | Register address to the cores |
| core_wdata | output | DATA_W | Data to the cores |
| core_dist_bus | input | N_CORES*DIST_W | Packed distance results, core i at bits i*DIST_W |
| core_cat_bus | input | N_CORES*CAT_W | Packed category results, core i at bits i*CAT_W |

## Verification
A corrupted phase counter shows first in the length of the window. Busy or the strobes fall a clock early or late, and the next falling-edge sample catches this. A wrong latched index or operation appears at once in the first window clock, as a wrong core_sel bit or a swapped strobe. A capture on the wrong phase shows one clock after the window, when rsp_valid pops a value that the scoreboard did not expect. The bench changes the core's result just before and just after the intended capture clock to expose this.

// File: rtl/mcd_pkg.sv
// Shared types for the multicore dispatch controller.
package mcd_pkg;
    // Kind of access performed in the current window.
    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } op_e;
endpackage

// File: rtl/mcd_sel_decode.sv
// Decodes a binary core index into a one-hot select and flags whether
// the index names an existing core. Assumes N_CORES >= 1.
module mcd_sel_decode #(
    parameter int N_CORES = 6,
    parameter int SEL_W   = 3
) (
    input  logic [SEL_W-1:0]   idx,
    output logic               in_range,
    output logic [N_CORES-1:0] onehot
);
    // Range check against the number of cores that exist.
    assign in_range = (int'(idx) < N_CORES);

    // One decoder bit per core.
    for (genvar g = 0; g < N_CORES; g++) begin : g_dec
        assign onehot[g] = (int'(idx) == g);
    end
endmodule

// File: rtl/mcd_phase_timer.sv
// Counts the controller clocks of one core-clock period. A start pulse
// opens a window of RATIO clocks; phase runs 0..RATIO-1. Assumes RATIO >= 2
// and that start is only given while the window is closed.
module mcd_phase_timer #(
    parameter int RATIO = 4,
    localparam int PH_W = $clog2(RATIO)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            running,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    // Window open flag and phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            phase   <= '0;
        end else if (start) begin
            running <= 1'b1;
            phase   <= '0;
        end else if (running) begin
            if (last) running <= 1'b0;
            else      phase   <= phase + 1'b1;
        end
    end

    // Final clock of the window.
    assign last = running && (phase == PH_W'(RATIO - 1));

    a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (int'(phase) < RATIO));

    a_r2_no_early_close: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !last) |=> running);

    a_r2_close_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !running);
endmodule

// File: rtl/mcd_result_sampler.sv
// Selects the addressed core's distance and category from the packed
// result buses and captures them on the capture strobe. Outputs hold
// between captures. Assumes sel is a valid index while capture is high.
module mcd_result_sampler #(
    parameter int N_CORES = 6,
    parameter int SEL_W   = 3,
    parameter int DIST_W  = 16,
    parameter int CAT_W   = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       capture,
    input  logic [SEL_W-1:0]           sel,
    input  logic [N_CORES*DIST_W-1:0]  dist_bus,
    input  logic [N_CORES*CAT_W-1:0]   cat_bus,
    output logic [DIST_W-1:0]          dist_q,
    output logic [CAT_W-1:0]           cat_q
);
    logic [DIST_W-1:0] dist_arr [N_CORES];
    logic [CAT_W-1:0]  cat_arr  [N_CORES];
    logic [DIST_W-1:0] dist_mux;
    logic [CAT_W-1:0]  cat_mux;

    // Unpack the per-core result fields.
    for (genvar g = 0; g < N_CORES; g++) begin : g_unpack
        assign dist_arr[g] = dist_bus[g*DIST_W +: DIST_W];
        assign cat_arr[g]  = cat_bus[g*CAT_W +: CAT_W];
    end

    // Pick the selected core's fields.
    always_comb begin
        dist_mux = '0;
        cat_mux  = '0;
        for (int i = 0; i < N_CORES; i++) begin
            if (int'(sel) == i) begin
                dist_mux = dist_arr[i];
                cat_mux  = cat_arr[i];
            end
        end
    end

    // Capture register: the sampling stage for the slow-domain results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dist_q <= '0;
            cat_q  <= '0;
        end else if (capture) begin
            dist_q <= dist_mux;
            cat_q  <= cat_mux;
        end
    end

    a_r9_hold_between_captures: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(dist_q) && $stable(cat_q)));
endmodule

// File: rtl/multicore_dispatch.sv
// Dispatch controller for parallel classifier cores on a slower clock.
// Takes one write or read request at a time, drives the chosen core for
// CLK_RATIO controller clocks, and for reads returns the captured
// distance and category with a one-cycle valid pulse. Assumes the core
// clock is phase-aligned so that one window equals one core period.
module multicore_dispatch #(
    parameter int N_CORES      = 6,
    parameter int ADDR_W       = 5,
    parameter int DATA_W       = 16,
    parameter int DIST_W       = 16,
    parameter int CAT_W        = 15,
    parameter int CLK_RATIO    = 4,
    parameter int SAMPLE_PHASE = 2,
    localparam int SEL_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int PH_W  = $clog2(CLK_RATIO)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_wr,
    input  logic                       req_rd,
    input  logic [SEL_W-1:0]           req_sel,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_data,
    output logic                       busy,
    output logic                       rsp_valid,
    output logic [DIST_W-1:0]          rsp_dist,
    output logic [CAT_W-1:0]           rsp_cat,
    output logic [N_CORES-1:0]         core_sel,
    output logic                       core_wr,
    output logic                       core_rd,
    output logic [ADDR_W-1:0]          core_addr,
    output logic [DATA_W-1:0]          core_wdata,
    input  logic [N_CORES*DIST_W-1:0]  core_dist_bus,
    input  logic [N_CORES*CAT_W-1:0]   core_cat_bus
);
    import mcd_pkg::*;

    logic               req_ok;
    logic [N_CORES-1:0] req_onehot;
    logic               start;
    logic               running;
    logic [PH_W-1:0]    phase;
    logic               last;
    logic               capture;
    op_e                op_q;
    logic [SEL_W-1:0]   sel_q;
    logic [N_CORES-1:0] onehot_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;

    mcd_sel_decode #(.N_CORES(N_CORES), .SEL_W(SEL_W)) u_dec (
        .idx      (req_sel),
        .in_range (req_ok),
        .onehot   (req_onehot)
    );

    // Accept a request only when idle and aimed at an existing core.
    assign start = (req_wr || req_rd) && req_ok && !running;

    mcd_phase_timer #(.RATIO(CLK_RATIO)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .running (running),
        .phase   (phase),
        .last    (last)
    );

    // Latch the accepted request; a read wins over a simultaneous write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_WRITE;
            sel_q    <= '0;
            onehot_q <= '0;
            addr_q   <= '0;
            data_q   <= '0;
        end else if (start) begin
            op_q     <= req_rd ? OP_READ : OP_WRITE;
            sel_q    <= req_sel;
            onehot_q <= req_onehot;
            addr_q   <= req_addr;
            data_q   <= req_data;
        end
    end

    // Drive the core control lines only inside a window.
    assign busy       = running;
    assign core_sel   = running ? onehot_q : '0;
    assign core_wr    = running && (op_q == OP_WRITE);
    assign core_rd    = running && (op_q == OP_READ);
    assign core_addr  = addr_q;
    assign core_wdata = data_q;

    // Sample point inside a read window.
    assign capture = core_rd && (phase == PH_W'(SAMPLE_PHASE));

    mcd_result_sampler #(
        .N_CORES (N_CORES),
        .SEL_W   (SEL_W),
        .DIST_W  (DIST_W),
        .CAT_W   (CAT_W)
    ) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .sel      (sel_q),
        .dist_bus (core_dist_bus),
        .cat_bus  (core_cat_bus),
        .dist_q   (rsp_dist),
        .cat_q    (rsp_cat)
    );

    // Valid pulse on the clock after a read window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= last && (op_q == OP_READ);
    end

    a_r2_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_wr && core_rd));

    a_r2_busy_one_core: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(core_sel) == 1));

    a_r6_window_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (busy && $stable(core_sel) && $stable(core_addr) &&
                             $stable(core_wdata) && $stable(core_wr) && $stable(core_rd)));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (core_sel == '0 && !core_wr && !core_rd));

    a_r7_bad_index_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_wr || req_rd) && !busy && int'(req_sel) >= N_CORES) |=> !busy);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r5_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(core_rd) && !busy));
endmodule

// File: tb/sim_multicore_dispatch.sv
module sim_multicore_dispatch;
    localparam int N  = 6;
    localparam int SW = 3;
    localparam int AW = 5;
    localparam int DW = 16;
    localparam int TW = 16;
    localparam int CW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_wr = 1'b0, req_rd = 1'b0;
    logic [SW-1:0] req_sel = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          busy, rsp_valid, core_wr, core_rd;
    logic [TW-1:0] rsp_dist;
    logic [CW-1:0] rsp_cat;
    logic [N-1:0]  core_sel;
    logic [AW-1:0] core_addr;
    logic [DW-1:0] core_wdata;
    logic [N*TW-1:0] dist_bus;
    logic [N*CW-1:0] cat_bus;
    logic [TW-1:0] dist_v [N];
    logic [CW-1:0] cat_v  [N];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [TW+CW-1:0] exp_q [$];

    always #4 clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_pack
        assign dist_bus[g*TW +: TW] = dist_v[g];
        assign cat_bus[g*CW +: CW]  = cat_v[g];
    end

    multicore_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
        .req_sel(req_sel), .req_addr(req_addr), .req_data(req_data),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_dist(rsp_dist), .rsp_cat(rsp_cat),
        .core_sel(core_sel), .core_wr(core_wr), .core_rd(core_rd),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_dist_bus(dist_bus), .core_cat_bus(cat_bus)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every result pulse must match the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected rsp_valid", 32'(rsp_valid), 32'd0);
            end else begin
                logic [TW+CW-1:0] e;
                e = exp_q.pop_front();
                chk({rsp_dist, rsp_cat} == e, "R4", "captured result",
                    32'({rsp_dist, rsp_cat}), 32'(e));
            end
        end
    end

    // Driver: one request, checks of the whole window, expectation pushed for reads.
    task automatic access(input bit wr, input bit rd, input int sel,
                          input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [TW-1:0] cap_d, input logic [CW-1:0] cap_c,
                          input bit poke, input string req);
        logic [N-1:0] exp_sel;
        logic [TW-1:0] old_d;
        logic [CW-1:0] old_c;
        exp_sel = N'(1) << sel;
        old_d = rsp_dist;
        old_c = rsp_cat;
        @(negedge clk);
        req_wr = wr; req_rd = rd; req_sel = SW'(sel); req_addr = a; req_data = d;
        if (rd) begin
            dist_v[sel] = ~cap_d;
            cat_v[sel]  = ~cap_c;
        end
        @(negedge clk);
        req_wr = 1'b0; req_rd = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(busy == 1'b1, req, "busy in window", 32'(busy), 32'd1);
            chk(core_sel == exp_sel, req, "core_sel", 32'(core_sel), 32'(exp_sel));
            chk(core_rd == rd && core_wr == !rd, req, "strobes {wr,rd}",
                32'({core_wr, core_rd}), 32'({!rd, rd}));
            chk(core_addr == a && core_wdata == d, req, "addr/data",
                32'({core_addr, core_wdata}), 32'({a, d}));
            if (poke && k == 0) begin
                req_wr = 1'b1; req_sel = SW'((sel + 1) % N);
                req_addr = ~a; req_data = ~d;
            end
            if (poke && k == 1) req_wr = 1'b0;
            if (rd && k == 2) begin
                dist_v[sel] = cap_d;
                cat_v[sel]  = cap_c;
                exp_q.push_back({cap_d, cap_c});
            end
            if (rd && k == 3) begin
                dist_v[sel] = cap_d ^ 16'h5A5A;
                cat_v[sel]  = cap_c ^ 15'h2AAA;
            end
            @(negedge clk);
        end
        chk(busy == 1'b0 && core_sel == '0 && !core_wr && !core_rd, req,
            "window closed after 4 clocks", 32'({busy, core_wr, core_rd}), 32'd0);
        chk(rsp_valid == rd, "R5", "valid after window", 32'(rsp_valid), 32'(rd));
        if (!rd)
            chk(rsp_dist == old_d && rsp_cat == old_c, "R9", "result held over write",
                32'({rsp_dist, rsp_cat}), 32'({old_d, old_c}));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R5", "valid one cycle", 32'(rsp_valid), 32'd0);
        chk(busy == 1'b0, "R6", "no second window", 32'(busy), 32'd0);
    endtask

    task automatic bad_index(input int sel, input bit rd);
        @(negedge clk);
        req_wr = !rd; req_rd = rd; req_sel = SW'(sel);
        @(negedge clk);
        req_wr = 1'b0; req_rd = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(!busy && core_sel == '0 && !core_wr && !core_rd && !rsp_valid, "R7",
                "bad index ignored", 32'({busy, core_sel, core_wr, core_rd}), 32'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            dist_v[i] = TW'(16'h1000 + i * 16'h0111);
            cat_v[i]  = CW'(i + 1);
        end
        repeat (3) @(negedge clk);
        chk(!busy && !rsp_valid && !core_wr && !core_rd && core_sel == '0, "R1",
            "outputs in reset", 32'({busy, rsp_valid, core_wr, core_rd, core_sel}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rsp_valid && !core_wr && !core_rd && core_sel == '0, "R1",
            "outputs after reset", 32'({busy, rsp_valid, core_wr, core_rd, core_sel}), 32'd0);
        chk(rsp_dist == '0 && rsp_cat == '0, "R1", "result cleared",
            32'({rsp_dist, rsp_cat}), 32'd0);

        access(1, 0, 0, 5'h03, 16'hBEEF, '0, '0, 0, "R2");
        access(1, 0, 5, 5'h1F, 16'h0001, '0, '0, 0, "R2");
        access(0, 1, 2, 5'h10, 16'h1234, 16'h00DC, 15'h0001, 0, "R3");
        access(0, 1, 5, 5'h0A, 16'hFFFF, 16'h0012, 15'h7ABC, 0, "R4");
        access(1, 0, 3, 5'h07, 16'hA5A5, '0, '0, 0, "R9");
        access(1, 0, 1, 5'h11, 16'h4321, '0, '0, 1, "R6");
        access(0, 1, 4, 5'h02, 16'h0F0F, 16'h0085, 15'h0003, 1, "R6");
        access(1, 1, 0, 5'h1C, 16'h7777, 16'h0075, 15'h0555, 0, "R8");
        bad_index(6, 0);
        bad_index(7, 1);
        access(0, 1, 3, 5'h01, 16'h0100, 16'hCAFE, 15'h1234, 0, "R4");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "all expected results delivered",
            32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule